// File: doc/BRIEF.md
# Processor Power State Controller

This block sequences the low-power states of an embedded processor core. From the running state it can put the core to sleep in two ways. In the first, the core reports that it has executed HALT: the block issues one halt bus cycle and then gates the core clock off until a wake request arrives. In the second, the system asks for the clock to stop: the block enters a grant state, acknowledges it, and enters a deeper stopped state if the input clock then disappears.

While the core is parked in the grant or stopped state, the block holds the data-bus keepers on, so the 16-bit data lines keep their last logic level. The two parity keepers, one per byte lane, stay on at all times. When the input clock returns, a fixed eight-cycle resynchronisation count runs. The core clock and the ready flag come back only when that count has finished. There is no wait for a long lock. Withdrawing the stop request from the grant state returns the core to running at once, with no count.

Top module: `pps_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, the block is in the running state: `core_clk_en`=1, `ready`=1, `halt_cycle_req`=0, `stop_ack`=0, `data_keep_en`=0.
- R2: A `halt_strobe` in the running state causes exactly one cycle of `halt_cycle_req`=1 with `core_clk_en` still 1. After that cycle, `core_clk_en` drops to 0 and stays 0 (halted). A `halt_strobe` in any other state has no effect.
- R3: A `wake_req` in the halted state sets `core_clk_en` to 1 again at the next clock edge. A `wake_req` in the running or grant state has no effect.
- R4: A `stop_req` seen in the running or halted state enters the grant state at the next edge: `core_clk_en`=0, `ready`=1, and `stop_ack`=1 for exactly one cycle. `stop_req` takes priority over `halt_strobe` and `wake_req` in the same cycle. It is not honoured during the halt bus cycle, but it is honoured once the halted state is reached.
- R5: Dropping `stop_req` in the grant state returns the block to running at the next edge, with no resynchronisation delay.
- R6: `clk_present` low in the grant state, with `stop_req` still high, enters the stopped state: `ready`=0 and `core_clk_en`=0.
- R7: `clk_present` seen high in the stopped state starts the resynchronisation. `ready` and `core_clk_en` both become 1 exactly 8 clock edges after the edge that sampled it. `stop_req` has no effect during the count.
- R8: If `clk_present` falls during the resynchronisation, the block goes back to the stopped state. The next restart counts the full 8 cycles again.
- R9: Every bit of `data_keep_en` (one per byte lane) is 1 exactly while the block is in the grant or stopped state, and 0 during the resynchronisation.
- R10: `parity_keep_en` has one bit per byte lane, and every bit is 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_req | input | 1 | Request to stop the core clock |
| halt_strobe | input | 1 | Core has executed HALT (one-cycle strobe) |
| wake_req | input | 1 | Interrupt or wake request |
| clk_present | input | 1 | Input clock is running |
| core_clk_en | output | 1 | Enable for the core clock gate |
| halt_cycle_req | output | 1 | Request to run a halt bus cycle |
| stop_ack | output | 1 | One-cycle acknowledge on entering the grant state |
| data_keep_en | output | DATA_W/8 | Data-bus keeper enable, one bit per byte lane |
| parity_keep_en | output | DATA_W/8 | Parity keeper enable, one bit per byte lane |
| ready | output | 1 | Core clock is synchronised and usable |

## Verification
The bench counts the restart window edge by edge. A counter that is off by one makes `ready` rise a cycle early or late, and a design that ignores `clk_present` falling mid-count finishes too soon after the second restart. It also raises `stop_req` during the halt bus cycle: a design that honours it there skips the halt cycle and pulses `stop_ack` too early. The bench also drops `stop_req` in the grant state, where a design that wrongly runs the count would hold `ready` or `core_clk_en` low. Finally, it sends `wake_req` and `halt_strobe` in states where they must be ignored, to catch a design that leaves the grant state or re-enters the halt cycle.

// File: rtl/pps_pkg.sv
// Package: shared state encoding for the processor power state controller.
// Assumes: all modules of the controller import this package.
package pps_pkg;

    typedef enum logic [2:0] {
        PS_RUN      = 3'd0,  // core running
        PS_HALTBUS  = 3'd1,  // issuing the halt bus cycle
        PS_HALTED   = 3'd2,  // core clock gated after HALT
        PS_GRANT    = 3'd3,  // stop granted, input clock still present
        PS_STOPPED  = 3'd4,  // input clock absent
        PS_RESYNC   = 3'd5   // clock back, counting resync cycles
    } pwr_state_e;

endpackage

// File: rtl/pps_resync_cnt.sv
// Module: counts the resynchronisation window after the input clock returns.
// Assumes: run is high for the whole window; dropping run clears the count,
// so every restart counts from zero. done is high in the last window cycle.
module pps_resync_cnt #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Last-cycle flag of the window.
    assign done = run && (cnt_q == LAST);

    // Advance while running, hold at the last value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pps_fsm.sv
// Module: power-state sequencer with the registered stop acknowledge.
// Assumes: the inputs are synchronous to clk; resync_done comes from the
// resync counter while the state is PS_RESYNC.
module pps_fsm
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       halt_strobe,
    input  logic       wake_req,
    input  logic       clk_present,
    input  logic       resync_done,
    output pwr_state_e state,
    output logic       ack_pulse
);
    pwr_state_e state_q, state_d;
    logic       ack_q;

    // Next-state selection; stop_req has priority over halt and wake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (stop_req)         state_d = PS_GRANT;
                else if (halt_strobe) state_d = PS_HALTBUS;
            end
            PS_HALTBUS:               state_d = PS_HALTED;
            PS_HALTED: begin
                if (stop_req)         state_d = PS_GRANT;
                else if (wake_req)    state_d = PS_RUN;
            end
            PS_GRANT: begin
                if (!stop_req)        state_d = PS_RUN;
                else if (!clk_present) state_d = PS_STOPPED;
            end
            PS_STOPPED: begin
                if (clk_present)      state_d = PS_RESYNC;
            end
            PS_RESYNC: begin
                if (!clk_present)     state_d = PS_STOPPED;
                else if (resync_done) state_d = PS_RUN;
            end
            default:                  state_d = PS_RUN;
        endcase
    end

    // State register and the one-cycle acknowledge on entering the grant state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= (state_d == PS_GRANT) && (state_q != PS_GRANT);
        end
    end

    assign state     = state_q;
    assign ack_pulse = ack_q;

endmodule

// File: rtl/pps_out_dec.sv
// Module: decodes the power state into the core and keeper controls.
// Assumes: LANES byte lanes, each with one data keeper and one parity keeper.
module pps_out_dec
    import pps_pkg::*;
#(
    parameter int LANES = 2
) (
    input  pwr_state_e       state,
    output logic             core_clk_en,
    output logic             halt_cycle_req,
    output logic             ready,
    output logic [LANES-1:0] data_keep_en,
    output logic [LANES-1:0] parity_keep_en
);
    logic parked;

    // Core clock runs only while running or issuing the halt cycle.
    assign core_clk_en    = (state == PS_RUN) || (state == PS_HALTBUS);
    assign halt_cycle_req = (state == PS_HALTBUS);
    // Ready is low while the input clock is gone or being resynchronised.
    assign ready          = (state != PS_STOPPED) && (state != PS_RESYNC);
    assign parked         = (state == PS_GRANT) || (state == PS_STOPPED);

    // Per-lane keeper enables.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_keep_en[g]   = parked;
        assign parity_keep_en[g] = 1'b1;
    end

endmodule

// File: rtl/pps_ctrl.sv
// Module: top of the processor power state controller.
// Assumes: DATA_W is a multiple of 8; clk is the block's own free-running
// clock, and clk_present reports whether the core's input clock runs.
module pps_ctrl #(
    parameter int DATA_W        = 16,
    parameter int RESYNC_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                halt_strobe,
    input  logic                wake_req,
    input  logic                clk_present,
    output logic                core_clk_en,
    output logic                halt_cycle_req,
    output logic                stop_ack,
    output logic [DATA_W/8-1:0] data_keep_en,
    output logic [DATA_W/8-1:0] parity_keep_en,
    output logic                ready
);
    localparam int LANES = DATA_W / 8;

    pps_pkg::pwr_state_e state;
    logic                resync_done;
    logic                resync_run;

    // The counter runs only in the resync state.
    assign resync_run = (state == pps_pkg::PS_RESYNC);

    pps_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .halt_strobe (halt_strobe),
        .wake_req    (wake_req),
        .clk_present (clk_present),
        .resync_done (resync_done),
        .state       (state),
        .ack_pulse   (stop_ack)
    );

    pps_resync_cnt #(.CYCLES(RESYNC_CYCLES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (resync_run),
        .done  (resync_done)
    );

    pps_out_dec #(.LANES(LANES)) u_dec (
        .state          (state),
        .core_clk_en    (core_clk_en),
        .halt_cycle_req (halt_cycle_req),
        .ready          (ready),
        .data_keep_en   (data_keep_en),
        .parity_keep_en (parity_keep_en)
    );

endmodule

// File: rtl/pps_ctrl_chk.sv
// Checker: port-level properties of pps_ctrl, attached by bind.
// Assumes: the same parameters as the bound instance.
module pps_ctrl_chk #(
    parameter int DATA_W        = 16,
    parameter int RESYNC_CYCLES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stop_req,
    input logic                halt_strobe,
    input logic                wake_req,
    input logic                clk_present,
    input logic                core_clk_en,
    input logic                halt_cycle_req,
    input logic                stop_ack,
    input logic [DATA_W/8-1:0] data_keep_en,
    input logic [DATA_W/8-1:0] parity_keep_en,
    input logic                ready
);
    logic [7:0] win_q;

    // Counts cycles with ready low and the input clock present (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || ready || !clk_present) win_q <= '0;
        else if (win_q != 8'hFF)             win_q <= win_q + 1'b1;
    end

    // R2: after the halt bus cycle the core clock is gated.
    a_r2_halt_then_gate: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cycle_req |=> (!core_clk_en && !halt_cycle_req));

    // R3: a wake in the halted state restores the core clock.
    a_r3_wake_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && ready && (data_keep_en == '0) && wake_req && !stop_req)
        |=> core_clk_en);

    // R4: the stop acknowledge lasts one cycle.
    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack |=> !stop_ack);

    // R4: stop is not honoured during the halt bus cycle.
    a_r4_no_stop_in_haltbus: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cycle_req |=> (!stop_ack && (data_keep_en == '0)));

    // R5: withdrawing stop from the grant state resumes at once.
    a_r5_grant_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_keep_en != '0) && ready && !stop_req) |=> (core_clk_en && ready));

    // R7: ready returns exactly after the resync window.
    a_r7_resync_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (core_clk_en && (win_q == 8'(RESYNC_CYCLES + 1))));

    // R9: keepers on only while the core clock is off.
    a_r9_keep_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
        (data_keep_en != '0) |-> !core_clk_en);

    // R10: parity keepers never drop.
    a_r10_parity_on: assert property (@(posedge clk) disable iff (!rst_n)
        (&parity_keep_en));

endmodule

bind pps_ctrl pps_ctrl_chk #(.DATA_W(DATA_W), .RESYNC_CYCLES(RESYNC_CYCLES)) u_chk (.*);

// File: tb/pps_ctrl_tb.sv
// Bench: directed scenarios for pps_ctrl, one task per scenario.
module pps_ctrl_tb;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;
    localparam int RS     = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stop_req = 1'b0;
    logic             halt_strobe = 1'b0;
    logic             wake_req = 1'b0;
    logic             clk_present = 1'b1;
    logic             core_clk_en;
    logic             halt_cycle_req;
    logic             stop_ack;
    logic [LANES-1:0] data_keep_en;
    logic [LANES-1:0] parity_keep_en;
    logic             ready;

    int checks = 0;
    int errors = 0;

    localparam logic [LANES-1:0] ALL = '1;
    localparam logic [LANES-1:0] NONE = '0;

    always #10 clk = ~clk;

    pps_ctrl #(.DATA_W(DATA_W), .RESYNC_CYCLES(RS)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .stop_req       (stop_req),
        .halt_strobe    (halt_strobe),
        .wake_req       (wake_req),
        .clk_present    (clk_present),
        .core_clk_en    (core_clk_en),
        .halt_cycle_req (halt_cycle_req),
        .stop_ack       (stop_ack),
        .data_keep_en   (data_keep_en),
        .parity_keep_en (parity_keep_en),
        .ready          (ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock edge; inputs were set before, outputs read at the negedge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; stop_req = 0; halt_strobe = 0; wake_req = 0; clk_present = 1;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "core_clk_en", 32'(core_clk_en), 1);
        chk("R1", "ready", 32'(ready), 1);
        chk("R1", "halt_cycle_req", 32'(halt_cycle_req), 0);
        chk("R1", "stop_ack", 32'(stop_ack), 0);
        chk("R1", "data_keep_en", 32'(data_keep_en), 32'(NONE));
        chk("R10", "parity_keep_en", 32'(parity_keep_en), 32'(ALL));
    endtask

    task automatic t_halt_wake();
        do_reset();
        wake_req = 1; step();                     // wake in running: ignored
        chk("R3", "wake ignored in run", 32'(core_clk_en), 1);
        wake_req = 0;
        halt_strobe = 1; step(); halt_strobe = 0;
        chk("R2", "halt_cycle_req", 32'(halt_cycle_req), 1);
        chk("R2", "clk on during halt cycle", 32'(core_clk_en), 1);
        step();
        chk("R2", "halt_cycle_req ends", 32'(halt_cycle_req), 0);
        chk("R2", "clk gated", 32'(core_clk_en), 0);
        halt_strobe = 1; step(); halt_strobe = 0; // ignored while halted
        chk("R2", "strobe ignored halted", 32'(halt_cycle_req), 0);
        step();
        chk("R2", "still gated", 32'(core_clk_en), 0);
        chk("R9", "no keep in halt", 32'(data_keep_en), 32'(NONE));
        wake_req = 1; step(); wake_req = 0;
        chk("R3", "wake resumes", 32'(core_clk_en), 1);
        chk("R3", "no halt cycle on wake", 32'(halt_cycle_req), 0);
    endtask

    task automatic t_grant();
        do_reset();
        stop_req = 1; halt_strobe = 1; step(); halt_strobe = 0;
        chk("R4", "stop_ack on entry", 32'(stop_ack), 1);
        chk("R4", "stop priority over halt", 32'(halt_cycle_req), 0);
        chk("R4", "clk off in grant", 32'(core_clk_en), 0);
        chk("R4", "ready in grant", 32'(ready), 1);
        chk("R9", "keep in grant", 32'(data_keep_en), 32'(ALL));
        wake_req = 1; step(); wake_req = 0;
        chk("R4", "stop_ack one cycle", 32'(stop_ack), 0);
        chk("R3", "wake ignored in grant", 32'(data_keep_en), 32'(ALL));
        halt_strobe = 1; step(); halt_strobe = 0;
        chk("R2", "strobe ignored in grant", 32'(halt_cycle_req), 0);
        stop_req = 0; step();
        chk("R5", "run after stop drop", 32'(core_clk_en), 1);
        chk("R5", "ready after stop drop", 32'(ready), 1);
        chk("R9", "keep released", 32'(data_keep_en), 32'(NONE));
    endtask

    task automatic t_stop_from_halt();
        do_reset();
        halt_strobe = 1; step(); halt_strobe = 0;
        stop_req = 1; step();                      // halt bus cycle: not honoured
        chk("R4", "no ack in halt cycle", 32'(stop_ack), 0);
        chk("R4", "no keep in halt cycle", 32'(data_keep_en), 32'(NONE));
        chk("R4", "halted after halt cycle", 32'(core_clk_en), 0);
        wake_req = 1; step(); wake_req = 0;        // stop has priority over wake
        chk("R4", "ack from halted", 32'(stop_ack), 1);
        chk("R4", "grant not run", 32'(core_clk_en), 0);
        chk("R9", "keep from halted", 32'(data_keep_en), 32'(ALL));
        stop_req = 0; step();
        chk("R5", "run after stop drop", 32'(core_clk_en), 1);
    endtask

    task automatic t_stop_clock();
        do_reset();
        stop_req = 1; step();
        clk_present = 0; step();
        chk("R6", "ready low stopped", 32'(ready), 0);
        chk("R6", "clk off stopped", 32'(core_clk_en), 0);
        chk("R9", "keep stopped", 32'(data_keep_en), 32'(ALL));
        step(); step();
        chk("R6", "stays stopped", 32'(ready), 0);
        clk_present = 1; stop_req = 0; step();     // edge that samples clock back
        chk("R9", "keep off in resync", 32'(data_keep_en), 32'(NONE));
        for (int i = 1; i < RS; i++) begin
            step();
            chk("R7", $sformatf("ready low edge %0d", i), 32'(ready), 0);
            chk("R7", $sformatf("clk off edge %0d", i), 32'(core_clk_en), 0);
        end
        step();
        chk("R7", "ready after 8", 32'(ready), 1);
        chk("R7", "clk after 8", 32'(core_clk_en), 1);
    endtask

    task automatic t_resync_abort();
        do_reset();
        stop_req = 1; step();
        clk_present = 0; step();
        clk_present = 1; step(); step(); step(); step();
        clk_present = 0; step();
        chk("R8", "back to stopped", 32'(data_keep_en), 32'(ALL));
        chk("R8", "ready low", 32'(ready), 0);
        clk_present = 1; step();
        for (int i = 1; i < RS; i++) begin
            step();
            chk("R8", $sformatf("recount edge %0d", i), 32'(ready), 0);
        end
        stop_req = 0; step();
        chk("R8", "ready after full recount", 32'(ready), 1);
        chk("R7", "stop ignored in resync", 32'(core_clk_en), 1);
        chk("R10", "parity kept", 32'(parity_keep_en), 32'(ALL));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_halt_wake();
        t_grant();
        t_stop_from_halt();
        t_stop_clock();
        t_resync_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule